// File: doc/BRIEF.md
# SDRAM Controller Configuration Register File

This block holds the configuration state of a memory controller and is reached through two register ports. Software first writes an internal offset into the address port. Every later access to the data port then reads or writes the register at that offset. The register set covers:

- two error status registers, set by hardware error flags;
- an error address register;
- a global control register and a read-only status register;
- refresh, power-management, timing and ECC control registers;
- an ECC error status register that drives an interrupt;
- one configuration register per memory bank.

A bank register gives the bank's base, a size code and an enable. A bank takes part in address mapping only while the global controller enable is also set. The block compares an incoming physical address against the mapped banks. It reports whether some bank covers the address and, if so, the index of the lowest-numbered covering bank. The status register is not written by software. It follows edges of two control bits. Command sequencing, refresh generation and the ECC datapath sit in other blocks.

Top module: `sdr_cfg_regfile`

## Requirements
- R1: After reset the control register is 0x00800000, power-management 0x07C00000, refresh 0x05F00000, timing 0x00854009. The address port, both error status registers, the error address, ECC control, ECC error status, status and all bank registers are zero.
- R2: A write to the address port (`acc_port`=0) stores `acc_wdata[7:0]` as the selected offset. A read of the address port returns that offset zero-extended. `acc_rdata` always reflects the selected register and needs no strobe.
- R3: Data writes store these values:
  - refresh (0x30): value AND 0x3FF80000;
  - timing (0x80): value AND 0x018FC01F;
  - ECC control (0x94): value AND 0x00F00000;
  - power-management (0x34): (value AND 0xF8000000) OR 0x07C00000;
  - error address (0x10), control (0x20) and ECC error status (0x98): the full value.
- R4: Error status 0 (0x00) and error status 1 (0x08) are write-one-to-clear: each data bit written as one clears that stored bit. A one on `err_set0`/`err_set1` sets the matching bit. A set and a clear of the same bit in the same cycle leave the bit set.
- R5: Writes to status (0x24) are ignored. When control bit 31 (controller enable) goes from 0 to 1, status bit 31 is cleared; when it goes from 1 to 0, status bit 31 is set.
- R6: When a control write changes control bit 30, status bit 30 takes the new value of that bit.
- R7: Bank register i sits at offset 0x40+4*i (four banks by default) and stores the written value AND 0xFFDEE001.
- R8: A bank covers an address only while its bit 0 and control bit 31 are both set. The bank size is 4 MiB shifted left by the code in bits 19:17. The base is bits 31:23, rounded down to a multiple of the size. The bank covers addresses from that base up to the base plus the size, exclusive.
- R9: `dec_hit` is high when any bank covers `dec_addr`. `dec_bank` is then the lowest-numbered covering bank, and is 0 when there is no hit.
- R10: `ecc_irq` is high exactly while the ECC error status register is nonzero. It changes in the same clock edge that writes that register.
- R11: Data reads of offsets not listed above return zero. Data writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Access strobe |
| acc_wr | input | 1 | 1 = write access |
| acc_port | input | 1 | 0 = address port, 1 = data port |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data of the port chosen by acc_port |
| err_set0 | input | 32 | Hardware set flags for error status 0 |
| err_set1 | input | 32 | Hardware set flags for error status 1 |
| dec_addr | input | 32 | Physical address to decode |
| dec_hit | output | 1 | Some mapped bank covers dec_addr |
| dec_bank | output | 2 | Index of the lowest covering bank |
| ecc_irq | output | 1 | ECC error status is nonzero |

## Verification
Two functions can land on an error status register in the same clock edge: a hardware error flag setting a bit, and a software write-one-to-clear of that same register. The bench preloads error status 0 through `err_set0`. It then drives, in one cycle, a clear of eight bits together with a set of four of them. The register must keep exactly the set bits and drop the rest. That shows the set takes precedence bit by bit, and that the clear is not lost on the other bits.

// File: rtl/sdr_cfg_pkg.sv
package sdr_cfg_pkg;

  localparam int DW    = 32;
  localparam int OFF_W = 8;

  // internal register offsets
  localparam logic [OFF_W-1:0] OFS_ERRST0 = 8'h00;
  localparam logic [OFF_W-1:0] OFS_ERRST1 = 8'h08;
  localparam logic [OFF_W-1:0] OFS_ERRADR = 8'h10;
  localparam logic [OFF_W-1:0] OFS_CTRL   = 8'h20;
  localparam logic [OFF_W-1:0] OFS_STAT   = 8'h24;
  localparam logic [OFF_W-1:0] OFS_RFSH   = 8'h30;
  localparam logic [OFF_W-1:0] OFS_PWRM   = 8'h34;
  localparam logic [OFF_W-1:0] OFS_BANK0  = 8'h40;
  localparam logic [OFF_W-1:0] OFS_TIMING = 8'h80;
  localparam logic [OFF_W-1:0] OFS_ECCCTL = 8'h94;
  localparam logic [OFF_W-1:0] OFS_ECCERR = 8'h98;

  // store masks
  localparam logic [DW-1:0] RFSH_KEEP   = 32'h3FF8_0000;
  localparam logic [DW-1:0] TIMING_KEEP = 32'h018F_C01F;
  localparam logic [DW-1:0] ECCCTL_KEEP = 32'h00F0_0000;
  localparam logic [DW-1:0] PWRM_KEEP   = 32'hF800_0000;
  localparam logic [DW-1:0] PWRM_FORCE  = 32'h07C0_0000;
  localparam logic [DW-1:0] BANK_KEEP   = 32'hFFDE_E001;
  localparam logic [DW-1:0] BANK_BASE   = 32'hFF80_0000;

  // reset values
  localparam logic [DW-1:0] CTRL_INIT   = 32'h0080_0000;
  localparam logic [DW-1:0] PWRM_INIT   = 32'h07C0_0000;
  localparam logic [DW-1:0] RFSH_INIT   = 32'h05F0_0000;
  localparam logic [DW-1:0] TIMING_INIT = 32'h0085_4009;

  localparam int CTRL_EN_BIT = 31;
  localparam int CTRL_SR_BIT = 30;
  localparam int MIN_SPAN_LOG2 = 22;

  function automatic logic [OFF_W-1:0] bank_offset(input int idx);
    return OFS_BANK0 + OFF_W'(4 * idx);
  endfunction

  function automatic logic [2:0] bank_code(input logic [DW-1:0] bcr);
    return bcr[19:17];
  endfunction

  // ones above the span of a bank of the given size code
  function automatic logic [DW-1:0] span_mask(input logic [2:0] code);
    return {DW{1'b1}} << (5'(MIN_SPAN_LOG2) + 5'(code));
  endfunction

  function automatic logic bank_covers(input logic [DW-1:0] bcr,
                                       input logic [DW-1:0] addr);
    logic [DW-1:0] m;
    m = span_mask(bank_code(bcr));
    return (addr & m) == (bcr & BANK_BASE & m);
  endfunction

endpackage

// File: rtl/sdr_bank_slot.sv
module sdr_bank_slot
  import sdr_cfg_pkg::*;
#(
  parameter int IDX = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             data_wr,
  input  logic [OFF_W-1:0] sel,
  input  logic [DW-1:0]    wdata,
  input  logic             glb_en,
  input  logic [DW-1:0]    probe_addr,
  output logic [DW-1:0]    bcr_q,
  output logic             covers
);

  localparam logic [OFF_W-1:0] MY_OFS = bank_offset(IDX);

  logic slot_wr;
  logic mapped;

  assign slot_wr = data_wr && (sel == MY_OFS);
  assign mapped  = glb_en && bcr_q[0];
  assign covers  = mapped && bank_covers(bcr_q, probe_addr);

  always_ff @(posedge clk) begin
    if (!rst_n)       bcr_q <= '0;
    else if (slot_wr) bcr_q <= wdata & BANK_KEEP;
  end

endmodule

// File: rtl/sdr_bank_decode.sv
module sdr_bank_decode #(
  parameter int NUM_BANKS = 4,
  parameter int BIDX_W    = 2
) (
  input  logic [NUM_BANKS-1:0] covers,
  output logic                 hit,
  output logic [BIDX_W-1:0]    idx
);

  always_comb begin
    hit = |covers;
    idx = '0;
    for (int i = NUM_BANKS - 1; i >= 0; i--) begin
      if (covers[i]) idx = BIDX_W'(i);
    end
  end

endmodule

// File: rtl/sdr_ctrl_status.sv
module sdr_ctrl_status
  import sdr_cfg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctrl_wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] ctrl_q,
  output logic [DW-1:0] stat_q,
  output logic          en_rise,
  output logic          en_fall,
  output logic          sr_change
);

  assign en_rise   = ctrl_wr && !ctrl_q[CTRL_EN_BIT] &&  wdata[CTRL_EN_BIT];
  assign en_fall   = ctrl_wr &&  ctrl_q[CTRL_EN_BIT] && !wdata[CTRL_EN_BIT];
  assign sr_change = ctrl_wr && (ctrl_q[CTRL_SR_BIT] != wdata[CTRL_SR_BIT]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_INIT;
      stat_q <= '0;
    end else begin
      if (ctrl_wr)   ctrl_q <= wdata;
      if (en_rise)   stat_q[CTRL_EN_BIT] <= 1'b0;
      if (en_fall)   stat_q[CTRL_EN_BIT] <= 1'b1;
      if (sr_change) stat_q[CTRL_SR_BIT] <= wdata[CTRL_SR_BIT];
    end
  end

endmodule

// File: rtl/sdr_cfg_regfile.sv
module sdr_cfg_regfile
  import sdr_cfg_pkg::*;
#(
  parameter int NUM_BANKS = 4
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  acc_en,
  input  logic                                  acc_wr,
  input  logic                                  acc_port,
  input  logic [31:0]                           acc_wdata,
  output logic [31:0]                           acc_rdata,
  input  logic [31:0]                           err_set0,
  input  logic [31:0]                           err_set1,
  input  logic [31:0]                           dec_addr,
  output logic                                  dec_hit,
  output logic [((NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1)-1:0] dec_bank,
  output logic                                  ecc_irq
);

  localparam int BIDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  logic             addr_wr, data_wr;
  logic [OFF_W-1:0] sel_q;
  logic [DW-1:0]    errst0_q, errst1_q, erradr_q, rfsh_q, pwrm_q;
  logic [DW-1:0]    timing_q, eccctl_q, eccerr_q;
  logic [DW-1:0]    ctrl_q, stat_q;
  logic             en_rise, en_fall, sr_change;
  logic [DW-1:0]    clr0, clr1;
  logic [DW-1:0]    bcr_q [NUM_BANKS];
  logic [NUM_BANKS-1:0] covers;
  logic [DW-1:0]    data_rd;

  assign addr_wr = acc_en && acc_wr && !acc_port;
  assign data_wr = acc_en && acc_wr &&  acc_port;

  function automatic logic wr_at(input logic dw, input logic [OFF_W-1:0] s,
                                 input logic [OFF_W-1:0] ofs);
    return dw && (s == ofs);
  endfunction

  assign clr0 = wr_at(data_wr, sel_q, OFS_ERRST0) ? acc_wdata : '0;
  assign clr1 = wr_at(data_wr, sel_q, OFS_ERRST1) ? acc_wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q    <= '0;
      errst0_q <= '0;
      errst1_q <= '0;
      erradr_q <= '0;
      rfsh_q   <= RFSH_INIT;
      pwrm_q   <= PWRM_INIT;
      timing_q <= TIMING_INIT;
      eccctl_q <= '0;
      eccerr_q <= '0;
    end else begin
      if (addr_wr) sel_q <= acc_wdata[OFF_W-1:0];
      errst0_q <= (errst0_q & ~clr0) | err_set0;
      errst1_q <= (errst1_q & ~clr1) | err_set1;
      if (wr_at(data_wr, sel_q, OFS_ERRADR)) erradr_q <= acc_wdata;
      if (wr_at(data_wr, sel_q, OFS_RFSH))   rfsh_q   <= acc_wdata & RFSH_KEEP;
      if (wr_at(data_wr, sel_q, OFS_PWRM))   pwrm_q   <= (acc_wdata & PWRM_KEEP) | PWRM_FORCE;
      if (wr_at(data_wr, sel_q, OFS_TIMING)) timing_q <= acc_wdata & TIMING_KEEP;
      if (wr_at(data_wr, sel_q, OFS_ECCCTL)) eccctl_q <= acc_wdata & ECCCTL_KEEP;
      if (wr_at(data_wr, sel_q, OFS_ECCERR)) eccerr_q <= acc_wdata;
    end
  end

  assign ecc_irq = |eccerr_q;

  sdr_ctrl_status u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_wr   (wr_at(data_wr, sel_q, OFS_CTRL)),
    .wdata     (acc_wdata),
    .ctrl_q    (ctrl_q),
    .stat_q    (stat_q),
    .en_rise   (en_rise),
    .en_fall   (en_fall),
    .sr_change (sr_change)
  );

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    sdr_bank_slot #(.IDX(g)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .data_wr    (data_wr),
      .sel        (sel_q),
      .wdata      (acc_wdata),
      .glb_en     (ctrl_q[CTRL_EN_BIT]),
      .probe_addr (dec_addr),
      .bcr_q      (bcr_q[g]),
      .covers     (covers[g])
    );
  end

  sdr_bank_decode #(.NUM_BANKS(NUM_BANKS), .BIDX_W(BIDX_W)) u_dec (
    .covers (covers),
    .hit    (dec_hit),
    .idx    (dec_bank)
  );

  always_comb begin
    data_rd = '0;
    case (sel_q)
      OFS_ERRST0: data_rd = errst0_q;
      OFS_ERRST1: data_rd = errst1_q;
      OFS_ERRADR: data_rd = erradr_q;
      OFS_CTRL:   data_rd = ctrl_q;
      OFS_STAT:   data_rd = stat_q;
      OFS_RFSH:   data_rd = rfsh_q;
      OFS_PWRM:   data_rd = pwrm_q;
      OFS_TIMING: data_rd = timing_q;
      OFS_ECCCTL: data_rd = eccctl_q;
      OFS_ECCERR: data_rd = eccerr_q;
      default:    data_rd = '0;
    endcase
    for (int i = 0; i < NUM_BANKS; i++) begin
      if (sel_q == bank_offset(i)) data_rd = bcr_q[i];
    end
  end

  assign acc_rdata = acc_port ? data_rd : {{(DW-OFF_W){1'b0}}, sel_q};

endmodule

// File: rtl/sdr_cfg_regfile_chk.sv
module sdr_cfg_regfile_chk
  import sdr_cfg_pkg::*;
#(
  parameter int BW = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             addr_wr,
  input logic             data_wr,
  input logic [DW-1:0]    acc_wdata,
  input logic [OFF_W-1:0] sel_q,
  input logic [DW-1:0]    ctrl_q,
  input logic [DW-1:0]    stat_q,
  input logic             en_rise,
  input logic             en_fall,
  input logic [DW-1:0]    errst0_q,
  input logic [DW-1:0]    err_set0,
  input logic             ecc_irq,
  input logic             dec_hit,
  input logic [BW-1:0]    dec_bank
);

  assert_sel_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    addr_wr |=> sel_q == $past(acc_wdata[OFF_W-1:0]));

  assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_set0) |=> ((errst0_q & $past(err_set0)) == $past(err_set0)));

  assert_en_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    en_rise |=> !stat_q[CTRL_EN_BIT]);

  assert_en_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    en_fall |=> stat_q[CTRL_EN_BIT]);

  assert_stat_ro_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && sel_q == OFS_STAT) |=> $stable(stat_q));

  assert_no_map_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[CTRL_EN_BIT] |-> !dec_hit);

  assert_idle_bank_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_hit |-> dec_bank == '0);

  assert_irq_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && sel_q == OFS_ECCERR && acc_wdata == '0) |=> !ecc_irq);

  assert_irq_raise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && sel_q == OFS_ECCERR && acc_wdata != '0) |=> ecc_irq);

endmodule

bind sdr_cfg_regfile sdr_cfg_regfile_chk #(.BW(BIDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .addr_wr   (addr_wr),
  .data_wr   (data_wr),
  .acc_wdata (acc_wdata),
  .sel_q     (sel_q),
  .ctrl_q    (ctrl_q),
  .stat_q    (stat_q),
  .en_rise   (en_rise),
  .en_fall   (en_fall),
  .errst0_q  (errst0_q),
  .err_set0  (err_set0),
  .ecc_irq   (ecc_irq),
  .dec_hit   (dec_hit),
  .dec_bank  (dec_bank)
);

// File: tb/test_sdr_cfg_regfile.sv
module test_sdr_cfg_regfile;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_en = 1'b0, acc_wr = 1'b0, acc_port = 1'b0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] acc_rdata;
  logic [31:0] err_set0 = '0, err_set1 = '0;
  logic [31:0] dec_addr = '0;
  logic        dec_hit;
  logic [1:0]  dec_bank;
  logic        ecc_irq;

  int n_checks = 0;
  int n_fails  = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdr_cfg_regfile i_sdr_cfg_regfile (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
    .acc_port(acc_port), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .err_set0(err_set0), .err_set1(err_set1), .dec_addr(dec_addr),
    .dec_hit(dec_hit), .dec_bank(dec_bank), .ecc_irq(ecc_irq)
  );

  task automatic check(input string req, input logic [31:0] got,
                       input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic port_write(input logic port, input logic [31:0] val);
    @(negedge clk);
    acc_en = 1'b1; acc_wr = 1'b1; acc_port = port; acc_wdata = val;
    @(negedge clk);
    acc_en = 1'b0; acc_wr = 1'b0;
  endtask

  task automatic wreg(input logic [7:0] ofs, input logic [31:0] val);
    port_write(1'b0, {24'h0, ofs});
    port_write(1'b1, val);
  endtask

  task automatic rreg(input logic [7:0] ofs, output logic [31:0] val);
    port_write(1'b0, {24'h0, ofs});
    acc_port = 1'b1;
    #1 val = acc_rdata;
  endtask

  task automatic expect_reg(input string req, input logic [7:0] ofs,
                            input logic [31:0] exp);
    logic [31:0] v;
    rreg(ofs, v);
    check(req, v, exp);
  endtask

  task automatic expect_dec(input string req, input logic [31:0] a,
                            input logic hit, input logic [1:0] bank);
    dec_addr = a;
    #1;
    check(req, {31'h0, dec_hit}, {31'h0, hit});
    check(req, {30'h0, dec_bank}, {30'h0, bank});
  endtask

  task automatic t_reset();
    expect_reg("R1 ctrl",   8'h20, 32'h0080_0000);
    expect_reg("R1 pwrm",   8'h34, 32'h07C0_0000);
    expect_reg("R1 rfsh",   8'h30, 32'h05F0_0000);
    expect_reg("R1 timing", 8'h80, 32'h0085_4009);
    expect_reg("R1 stat",   8'h24, 32'h0);
    expect_reg("R1 errst0", 8'h00, 32'h0);
    expect_reg("R1 eccerr", 8'h98, 32'h0);
    expect_reg("R1 bank2",  8'h48, 32'h0);
    check("R1 irq", {31'h0, ecc_irq}, 32'h0);
  endtask

  task automatic t_addr_port();
    port_write(1'b0, 32'hFFFF_FF94);
    acc_port = 1'b0;
    #1 check("R2 addr readback", acc_rdata, 32'h0000_0094);
  endtask

  task automatic t_masks();
    wreg(8'h30, 32'hFFFF_FFFF);
    expect_reg("R3 rfsh", 8'h30, 32'h3FF8_0000);
    wreg(8'h80, 32'hFFFF_FFFF);
    expect_reg("R3 timing", 8'h80, 32'h018F_C01F);
    wreg(8'h94, 32'hFFFF_FFFF);
    expect_reg("R3 eccctl", 8'h94, 32'h00F0_0000);
    wreg(8'h34, 32'h0000_0000);
    expect_reg("R3 pwrm zero", 8'h34, 32'h07C0_0000);
    wreg(8'h34, 32'hA800_1234);
    expect_reg("R3 pwrm", 8'h34, 32'hAFC0_0000);
    wreg(8'h10, 32'hDEAD_BEEF);
    expect_reg("R3 erradr", 8'h10, 32'hDEAD_BEEF);
  endtask

  task automatic t_w1c();
    @(negedge clk);
    err_set0 = 32'h0000_000F; err_set1 = 32'h8000_0001;
    @(negedge clk);
    err_set0 = '0; err_set1 = '0;
    expect_reg("R4 set", 8'h00, 32'h0000_000F);
    wreg(8'h08, 32'h0000_0001);
    expect_reg("R4 w1c", 8'h08, 32'h8000_0000);
    // same-cycle: clear 0xFF while hardware sets 0xF0
    port_write(1'b0, 32'h0);
    @(negedge clk);
    acc_en = 1'b1; acc_wr = 1'b1; acc_port = 1'b1; acc_wdata = 32'h0000_00FF;
    err_set0 = 32'h0000_00F0;
    @(negedge clk);
    acc_en = 1'b0; acc_wr = 1'b0; err_set0 = '0;
    expect_reg("R4 set beats clear", 8'h00, 32'h0000_00F0);
  endtask

  task automatic t_status();
    wreg(8'h24, 32'hFFFF_FFFF);
    expect_reg("R5 stat ignores write", 8'h24, 32'h0);
    wreg(8'h20, 32'h8080_0000);
    expect_reg("R5 rise keeps clear", 8'h24, 32'h0);
    wreg(8'h20, 32'h0080_0000);
    expect_reg("R5 fall sets", 8'h24, 32'h8000_0000);
    wreg(8'h20, 32'hC080_0000);
    expect_reg("R5 R6 rise", 8'h24, 32'h4000_0000);
    wreg(8'h20, 32'h8080_0000);
    expect_reg("R6 sr cleared", 8'h24, 32'h0);
  endtask

  task automatic t_banks();
    wreg(8'h4C, 32'hFFFF_FFFF);
    expect_reg("R7 bank3 mask", 8'h4C, 32'hFFDE_E001);
    wreg(8'h4C, 32'h0);
    wreg(8'h20, 32'h0080_0000);              // global enable off
    wreg(8'h40, 32'h1004_0001);              // 16 MiB at 0x10000000
    expect_dec("R8 global off", 32'h1000_0000, 1'b0, 2'd0);
    wreg(8'h20, 32'h8080_0000);
    expect_dec("R8 low edge", 32'h1000_0000, 1'b1, 2'd0);
    expect_dec("R8 top", 32'h10FF_FFFF, 1'b1, 2'd0);
    expect_dec("R8 past end", 32'h1100_0000, 1'b0, 2'd0);
    expect_dec("R8 below", 32'h0FFF_FFFF, 1'b0, 2'd0);
    wreg(8'h44, 32'h1100_0001);              // 4 MiB at 0x11000000
    wreg(8'h48, 32'h1006_0001);              // 32 MiB at 0x10000000
    expect_dec("R9 bank1 before bank2", 32'h1100_0000, 1'b1, 2'd1);
    expect_dec("R9 bank0 before bank2", 32'h1000_0004, 1'b1, 2'd0);
    expect_dec("R9 bank2 only", 32'h1180_0000, 1'b1, 2'd2);
    wreg(8'h40, 32'h1004_0000);              // bank0 own enable off
    expect_dec("R8 bank enable off", 32'h1000_0004, 1'b1, 2'd2);
    wreg(8'h20, 32'h0080_0000);
    expect_dec("R8 global cleared", 32'h1180_0000, 1'b0, 2'd0);
  endtask

  task automatic t_ecc();
    wreg(8'h98, 32'h0000_0005);
    check("R10 irq up", {31'h0, ecc_irq}, 32'h1);
    expect_reg("R10 eccerr", 8'h98, 32'h0000_0005);
    wreg(8'h98, 32'h0);
    check("R10 irq down", {31'h0, ecc_irq}, 32'h0);
  endtask

  task automatic t_unlisted();
    wreg(8'h04, 32'hFFFF_FFFF);
    expect_reg("R11 read zero", 8'h04, 32'h0);
    wreg(8'h99, 32'hFFFF_FFFF);
    expect_reg("R11 read zero 99", 8'h99, 32'h0);
    expect_reg("R11 rfsh untouched", 8'h30, 32'h3FF8_0000);
    expect_reg("R11 erradr untouched", 8'h10, 32'hDEAD_BEEF);
    expect_reg("R11 eccerr untouched", 8'h98, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_addr_port();
    t_masks();
    t_w1c();
    t_status();
    t_banks();
    t_ecc();
    t_unlisted();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

endmodule